// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Timer

This block drives a group of edge-aligned PWM outputs from one free-running up-counter. The counter runs from zero up to a shared period value inclusive, then wraps, so every channel has the same period. Each channel compares the count against its own compare value and has its own polarity and output mask. The counter is advanced by one of three tick sources, chosen by a select field and gated by an enable input. A power-of-two prescaler then divides the chosen ticks.

Software reaches the block through a word-addressed register bus: one write strobe, with the read data taken combinationally from the address. A write-protect latch can freeze the timing configuration while the mask register stays writable. Period and compare writes go into shadow registers. These are copied into the working copies at the counter wrap, or at once while the counter has no clock source.

Top module: `pwm_timer_shared`

## Requirements
- R1: After reset the count is 0, the mask register reads all ones, the protect flag reads 0, and every output sits at its inactive level.
- R2: The count goes from 0 up to the period value (word address 1) inclusive and then wraps to 0, so one period lasts period+1 prescaled ticks. The count reads at word address 2.
- R3: The prescaler field, control word (address 0) bits [4:2] = p, lets the counter advance once every 2^p selected ticks.
- R4: The source field, control bits [1:0], picks the tick: 0 stops the counter, which holds its value; 1 takes tick_sys, 2 takes tick_fix, 3 takes tick_ext. A selected tick counts only while count_gate is high.
- R5: Each channel n has a mode word at address 8+2n. A channel produces PWM only when both bit 1 (mode) and bit 0 (edge level) are set. In that case its pre-polarity output is high while count < compare and low otherwise. With any other mode word, the pre-polarity output is low.
- R6: A compare value of 0 gives a constant low pre-polarity output. A compare value greater than the period gives a constant high one.
- R7: Bit n of the mask register (address 3) forces output n to its inactive level, which equals its polarity bit. The mask resets to all ones and is never write-protected.
- R8: Bit n of the polarity register (address 4) inverts output n.
- R9: Writing 1 to bit 0 of address 5 sets the protect flag. While the flag is set, writes to the control word, period, polarity, mode and compare registers are ignored, but reads still return their contents. Writing 1 to bit 0 of address 6 clears the flag.
- R10: A write to the period or to a compare value (address 9+2n) takes effect only when the counter wraps. While the source field is 0, it takes effect at once.
- R11: When the per-channel enable variant is built (HAS_CH_EN=1), a low in control bit 16+n holds output n at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Word address |
| bus_wr | input | 1 | Write strobe, accepted in the same cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_sys | input | 1 | System tick enable |
| tick_fix | input | 1 | Fixed-rate tick enable |
| tick_ext | input | 1 | External tick enable |
| count_gate | input | 1 | Enables counting of the selected tick |
| pwm_o | output | NCH | PWM outputs |

## Verification
The bench builds the block with four channels, an 8-bit counter and the per-channel enable variant switched on. With these settings, every requirement is reachable, including R11, within a few hundred cycles. The short period of 9, and later 5, lets whole periods and the shadow handover at a wrap be checked cycle by cycle against a model of the count and the outputs. The compare values sit on both sides of the period, which exercises the 0% and 100% corners alongside ordinary duty values.

// File: rtl/pwm_tmr_pkg.sv
`timescale 1ns/1ps
package pwm_tmr_pkg;
    localparam int unsigned BUS_W     = 32;
    localparam int unsigned PS_W      = 3;
    localparam int unsigned A_CTRL    = 0;
    localparam int unsigned A_PERIOD  = 1;
    localparam int unsigned A_COUNT   = 2;
    localparam int unsigned A_MASK    = 3;
    localparam int unsigned A_POL     = 4;
    localparam int unsigned A_PROT    = 5;
    localparam int unsigned A_UNLOCK  = 6;
    localparam int unsigned A_CH_BASE = 8;
    localparam int unsigned CHEN_LSB  = 16;

    typedef enum logic [1:0] {
        SRC_OFF = 2'd0,
        SRC_SYS = 2'd1,
        SRC_FIX = 2'd2,
        SRC_EXT = 2'd3
    } src_e;
endpackage

// File: rtl/pwm_tmr_prescale.sv
`timescale 1ns/1ps
module pwm_tmr_prescale
    import pwm_tmr_pkg::*;
#(
    parameter int unsigned PSW = PS_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  src_e           src_i,
    input  logic           gate_i,
    input  logic           tick_sys_i,
    input  logic           tick_fix_i,
    input  logic           tick_ext_i,
    input  logic [PSW-1:0] ps_i,
    output logic           tick_o
);
    localparam int unsigned PRE_W = (1 << PSW) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } st_t;

    st_t              s_d, s_q;
    logic             sel_tick;
    logic [PRE_W-1:0] lim;

    always_comb begin
        unique case (src_i)
            SRC_SYS: sel_tick = gate_i && tick_sys_i;
            SRC_FIX: sel_tick = gate_i && tick_fix_i;
            SRC_EXT: sel_tick = gate_i && tick_ext_i;
            default: sel_tick = 1'b0;
        endcase
        lim    = ~({PRE_W{1'b1}} << ps_i);
        s_d    = s_q;
        tick_o = 1'b0;
        if (src_i == SRC_OFF) begin
            s_d.pre = '0;
        end else if (sel_tick) begin
            if (s_q.pre >= lim) begin
                s_d.pre = '0;
                tick_o  = 1'b1;
            end else begin
                s_d.pre = s_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: with a divider above one, two prescaled ticks never come back to back
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o && (ps_i != '0) |=> !tick_o || (ps_i != $past(ps_i)));
endmodule

// File: rtl/pwm_tmr_counter.sv
`timescale 1ns/1ps
module pwm_tmr_counter #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic [CW-1:0] per_sh_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] per_o,
    output logic          load_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] per;
    } st_t;

    st_t  s_d, s_q;
    logic wrap;

    always_comb begin
        wrap   = tick_i && (s_q.cnt >= s_q.per);
        load_o = wrap || !run_i;
        s_d    = s_q;
        if (wrap)        s_d.cnt = '0;
        else if (tick_i) s_d.cnt = s_q.cnt + 1'b1;
        if (load_o)      s_d.per = per_sh_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign per_o = s_q.per;

    // R2: a tick at or past the terminal count returns the counter to zero
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && (s_q.cnt >= s_q.per) |=> s_q.cnt == '0);
    // R4: with no source selected the count holds
    a_r4_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(s_q.cnt));
    // R10: the working period changes only at a wrap or while stopped
    a_r10_period_steady: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && !(tick_i && (s_q.cnt >= s_q.per)) |=> $stable(s_q.per));
endmodule

// File: rtl/pwm_tmr_channel.sv
`timescale 1ns/1ps
module pwm_tmr_channel #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] cmp_sh_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] per_i,
    input  logic          mode_i,
    input  logic          en_i,
    input  logic          mask_i,
    input  logic          pol_i,
    output logic          out_o
);
    typedef struct packed {
        logic [CW-1:0] cmp;
    } st_t;

    st_t  s_d, s_q;
    logic raw;
    logic active;

    always_comb begin
        s_d = s_q;
        if (load_i) s_d.cmp = cmp_sh_i;
        raw    = mode_i && (cnt_i < s_q.cmp);
        active = en_i && !mask_i;
        out_o  = active ? (raw ^ pol_i) : pol_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7: a masked channel sits at its inactive level
    a_r7_mask_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i |-> out_o == pol_i);
    // R6: a compare above the period keeps the channel active all period
    a_r6_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i && en_i && !mask_i && (s_q.cmp > per_i) && (cnt_i <= per_i)
        |-> out_o == !pol_i);
    // R10: the working compare changes only on a load
    a_r10_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(s_q.cmp));
endmodule

// File: rtl/pwm_timer_shared.sv
`timescale 1ns/1ps
module pwm_timer_shared
    import pwm_tmr_pkg::*;
#(
    parameter int unsigned NCH       = 8,
    parameter int unsigned CW        = 16,
    parameter int unsigned HAS_CH_EN = 0,
    parameter int unsigned AW        = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             tick_sys,
    input  logic             tick_fix,
    input  logic             tick_ext,
    input  logic             count_gate,
    output logic [NCH-1:0]   pwm_o
);
    typedef struct packed {
        src_e                       src;
        logic [PS_W-1:0]            ps;
        logic [NCH-1:0]             chen;
        logic [CW-1:0]              per;
        logic [NCH-1:0]             mask;
        logic [NCH-1:0]             pol;
        logic                       wp;
        logic [NCH-1:0][1:0]        ctl;
        logic [NCH-1:0][CW-1:0]     cmp;
    } regs_t;

    regs_t          r_d, r_q;
    logic           tick;
    logic           run;
    logic           load;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  per_act;
    logic [NCH-1:0] ch_en;

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            if (!r_q.wp) begin
                if (bus_addr == AW'(A_CTRL)) begin
                    r_d.src = src_e'(bus_wdata[1:0]);
                    r_d.ps  = bus_wdata[2 +: PS_W];
                    if (HAS_CH_EN != 0) r_d.chen = bus_wdata[CHEN_LSB +: NCH];
                end
                if (bus_addr == AW'(A_PERIOD)) r_d.per = bus_wdata[CW-1:0];
                if (bus_addr == AW'(A_POL))    r_d.pol = bus_wdata[NCH-1:0];
                for (int n = 0; n < NCH; n++) begin
                    if (bus_addr == AW'(A_CH_BASE + 2 * n))     r_d.ctl[n] = bus_wdata[1:0];
                    if (bus_addr == AW'(A_CH_BASE + 2 * n + 1)) r_d.cmp[n] = bus_wdata[CW-1:0];
                end
            end
            if (bus_addr == AW'(A_MASK))                  r_d.mask = bus_wdata[NCH-1:0];
            if (bus_addr == AW'(A_PROT)   && bus_wdata[0]) r_d.wp   = 1'b1;
            if (bus_addr == AW'(A_UNLOCK) && bus_wdata[0]) r_d.wp   = 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(A_CTRL)) begin
            bus_rdata[1:0]               = r_q.src;
            bus_rdata[2 +: PS_W]         = r_q.ps;
            bus_rdata[CHEN_LSB +: NCH]   = r_q.chen;
        end
        if (bus_addr == AW'(A_PERIOD)) bus_rdata[CW-1:0]  = r_q.per;
        if (bus_addr == AW'(A_COUNT))  bus_rdata[CW-1:0]  = cnt;
        if (bus_addr == AW'(A_MASK))   bus_rdata[NCH-1:0] = r_q.mask;
        if (bus_addr == AW'(A_POL))    bus_rdata[NCH-1:0] = r_q.pol;
        if (bus_addr == AW'(A_PROT))   bus_rdata[0]       = r_q.wp;
        for (int n = 0; n < NCH; n++) begin
            if (bus_addr == AW'(A_CH_BASE + 2 * n))     bus_rdata[1:0]    = r_q.ctl[n];
            if (bus_addr == AW'(A_CH_BASE + 2 * n + 1)) bus_rdata[CW-1:0] = r_q.cmp[n];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mask <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign run = (r_q.src != SRC_OFF);

    generate
        if (HAS_CH_EN != 0) begin : g_chen
            assign ch_en = r_q.chen;
        end else begin : g_no_chen
            assign ch_en = '1;
        end
    endgenerate

    pwm_tmr_prescale #(.PSW(PS_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (r_q.src),
        .gate_i     (count_gate),
        .tick_sys_i (tick_sys),
        .tick_fix_i (tick_fix),
        .tick_ext_i (tick_ext),
        .ps_i       (r_q.ps),
        .tick_o     (tick)
    );

    pwm_tmr_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .tick_i   (tick),
        .per_sh_i (r_q.per),
        .cnt_o    (cnt),
        .per_o    (per_act),
        .load_o   (load)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_tmr_channel #(.CW(CW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (load),
            .cmp_sh_i (r_q.cmp[g]),
            .cnt_i    (cnt),
            .per_i    (per_act),
            .mode_i   (r_q.ctl[g] == 2'b11),
            .en_i     (ch_en[g]),
            .mask_i   (r_q.mask[g]),
            .pol_i    (r_q.pol[g]),
            .out_o    (pwm_o[g])
        );
    end

    // R9: a protected period write leaves the shadow period untouched
    a_r9_wp_blocks_period: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && r_q.wp && (bus_addr == AW'(A_PERIOD)) |=> $stable(r_q.per));
    // R9: the unlock write clears the protect flag
    a_r9_unlock_clears: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (bus_addr == AW'(A_UNLOCK)) && bus_wdata[0] |=> !r_q.wp);
endmodule

// File: tb/test_pwm_timer_shared.sv
`timescale 1ns/1ps
module test_pwm_timer_shared;
    localparam int NCH = 4;
    localparam int CW  = 8;
    localparam int AW  = 5;
    localparam int CH  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic           tick_sys = 1'b0, tick_fix = 1'b0, tick_ext = 1'b0, count_gate = 1'b0;
    logic [NCH-1:0] pwm_o;

    always #2 clk = ~clk;

    pwm_timer_shared #(.NCH(NCH), .CW(CW), .HAS_CH_EN(1), .AW(AW)) i_pwm_timer_shared (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_sys(tick_sys),
        .tick_fix(tick_fix), .tick_ext(tick_ext), .count_gate(count_gate), .pwm_o(pwm_o)
    );

    int n_chk = 0, n_err = 0;
    logic done = 1'b0;
    logic strobe = 1'b0;
    string          q_tag[$];
    logic           q_rdon[$];
    logic [31:0]    q_rd[$];
    logic [NCH-1:0] q_pmask[$];
    logic [NCH-1:0] q_pwm[$];

    int             m_cmp[NCH];
    int             m_ctl[NCH];
    logic [NCH-1:0] m_pol, m_mask, m_en;

    function automatic logic [NCH-1:0] model_pwm(int c);
        logic [NCH-1:0] r;
        for (int n = 0; n < NCH; n++) begin
            logic raw;
            raw  = (m_ctl[n] == 3) && (c < m_cmp[n]);
            r[n] = (m_en[n] && !m_mask[n]) ? (raw ^ m_pol[n]) : m_pol[n];
        end
        return r;
    endfunction

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        strobe = 1'b0; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    endtask

    task automatic chk(string tag, int a, logic rdon, logic [31:0] erd,
                       logic [NCH-1:0] pm, logic [NCH-1:0] ep);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = AW'(a);
        q_tag.push_back(tag); q_rdon.push_back(rdon); q_rd.push_back(erd);
        q_pmask.push_back(pm); q_pwm.push_back(ep);
        strobe = 1'b1;
    endtask

    task automatic sample_cnt(output int v);
        @(negedge clk);
        bus_wr = 1'b0; strobe = 1'b0; bus_addr = AW'(2);
        #1 v = int'(bus_rdata);
    endtask

    task automatic wait_cnt(int v);
        for (int i = 0; i < 1000; i++) begin
            int c;
            sample_cnt(c);
            if (c == v) break;
        end
    endtask

    // monitor: pops the expected item and compares it against the ports
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (strobe && q_tag.size() > 0) begin
                string tg; logic ron; logic [31:0] erd; logic [NCH-1:0] pm, ep;
                tg = q_tag.pop_front(); ron = q_rdon.pop_front(); erd = q_rd.pop_front();
                pm = q_pmask.pop_front(); ep = q_pwm.pop_front();
                n_chk++;
                if (ron && bus_rdata !== erd) begin
                    n_err++;
                    $display("FAIL %s: rdata actual %0h expected %0h", tg, bus_rdata, erd);
                end else if ((pwm_o & pm) !== (ep & pm)) begin
                    n_err++;
                    $display("FAIL %s: pwm actual %b expected %b (mask %b)", tg, pwm_o, ep, pm);
                end
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog (all requirements): actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int c, c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R7 reset state
        chk("R1 R7 mask reset", 3, 1, 32'hF, '1, '0);
        chk("R1 count reset",  2, 1, 32'h0, '1, '0);
        chk("R1 protect reset", 5, 1, 32'h0, '1, '0);

        tick_sys = 1'b1; count_gate = 1'b1;
        wr(1, 9);
        wr(CH + 0, 3); wr(CH + 1, 3);
        wr(CH + 2, 3); wr(CH + 3, 0);
        wr(CH + 4, 3); wr(CH + 5, 12);
        wr(CH + 6, 3); wr(CH + 7, 5);
        wr(4, 32'h8);
        wr(0, 32'h000F_0000);
        chk("R7 masked outputs at polarity", 3, 1, 32'hF, '1, 4'b1000);
        wr(3, 0);
        m_cmp = '{3, 0, 12, 5}; m_ctl = '{3, 3, 3, 3};
        m_pol = 4'b1000; m_mask = '0; m_en = 4'hF;
        wr(0, 32'h000F_0001);

        // R2 R5 R6 R8: one full period
        wait_cnt(0);
        for (int k = 1; k <= 10; k++) begin
            c = k % 10;
            chk("R2 R5 R6 R8 period", 2, 1, 32'(c), '1, model_pwm(c));
        end

        // R10: period and compare shadows apply at the wrap
        wait_cnt(2);
        wr(1, 5);
        wr(CH + 1, 1);
        begin
            int per_act;
            per_act = 9; c = 4;
            for (int k = 0; k < 12; k++) begin
                if (c >= per_act) begin c = 0; per_act = 5; m_cmp[0] = 1; end
                else c++;
                chk("R10 shadow handover", 2, 1, 32'(c), '1, model_pwm(c));
            end
        end

        // R3: divide by 4
        wr(0, 32'h000F_0009);
        wait_cnt(0);
        wait_cnt(1);
        for (int k = 1; k <= 7; k++) begin
            c = (k < 4) ? 1 : 2;
            chk("R3 prescale by 4", 2, 1, 32'(c), '1, model_pwm(c));
        end

        // R4: source select and gate
        tick_fix = 1'b0;
        wr(0, 32'h000F_0002);
        sample_cnt(c0);
        for (int k = 0; k < 3; k++) chk("R4 fix source idle", 2, 1, 32'(c0), '0, '0);
        tick_fix = 1'b1;
        sample_cnt(c0);
        chk("R4 fix source counts", 2, 1, (c0 >= 5) ? 32'h0 : 32'(c0 + 1), '0, '0);
        count_gate = 1'b0; tick_ext = 1'b1;
        wr(0, 32'h000F_0003);
        sample_cnt(c0);
        for (int k = 0; k < 2; k++) chk("R4 gate low holds", 2, 1, 32'(c0), '0, '0);
        count_gate = 1'b1;
        sample_cnt(c0);
        chk("R4 ext source counts", 2, 1, (c0 >= 5) ? 32'h0 : 32'(c0 + 1), '0, '0);
        wr(0, 32'h000F_0000);
        sample_cnt(c0);
        for (int k = 0; k < 2; k++) chk("R4 source off holds", 2, 1, 32'(c0), '0, '0);
        wr(0, 32'h000F_0001);

        // R9: write protection
        wr(5, 1);
        chk("R9 protect set", 5, 1, 32'h1, '0, '0);
        wr(1, 7);
        chk("R9 period blocked", 1, 1, 32'h5, '0, '0);
        wr(4, 0);
        chk("R9 polarity blocked", 4, 1, 32'h8, '0, '0);
        wr(CH + 1, 9);
        chk("R9 compare blocked", CH + 1, 1, 32'h1, '0, '0);
        wr(CH + 0, 0);
        chk("R9 mode blocked", CH + 0, 1, 32'h3, '0, '0);
        wr(3, 4); m_mask = 4'b0100;
        chk("R7 R9 mask writable under protect", 3, 1, 32'h4, 4'b0100, 4'b0000);
        wr(6, 1);
        chk("R9 unlock", 5, 1, 32'h0, '0, '0);
        wr(4, 0); m_pol = '0;
        chk("R8 R9 polarity after unlock", 4, 1, 32'h0, '0, '0);
        wr(3, 0); m_mask = '0;

        // R11: channel enable bit 16+2 cleared
        wr(0, 32'h000B_0001); m_en = 4'b1011;
        wait_cnt(0);
        for (int k = 1; k <= 6; k++) begin
            c = k % 6;
            chk("R11 channel disabled", 2, 1, 32'(c), '1, model_pwm(c));
        end

        // R5: mode word without the edge bit gives a low output
        wr(0, 32'h000F_0001); m_en = 4'hF;
        wr(CH + 6, 2); m_ctl[3] = 2;
        wait_cnt(0);
        for (int k = 1; k <= 6; k++) begin
            c = k % 6;
            chk("R5 non-PWM mode word", 2, 1, 32'(c), '1, model_pwm(c));
        end

        @(negedge clk); strobe = 1'b0; bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule